// File: doc/BRIEF.md
# Dual-trigger exposure window sequencer

This block times an image sensor's exposure window from two independent trigger lines. One line opens the window and the other closes it. A trigger counts only after its synchronized level has stayed high for a minimum number of clocks. A fixed open latency or close latency then runs, counted from the moment the trigger qualifies.

A fixed number of cycles after each window closes, the block emits a one-cycle readout-start pulse. That readout runs while the next frame's window is already open, so frame N-1 is read out during the exposure of frame N. The block enforces a minimum window length: if a close request would end the window too early, the window stays open until the minimum is met.

Three sticky flags report misuse. One is set by a trigger pulse that is too short, one by a window that had to be stretched, and one by an open request that arrived while a window was busy. All delays are parameters counted in clock cycles. The defaults are an open latency of 10, a close latency of 130, a readout latency of 100, a minimum window of 500 and a minimum trigger high time of 100.

Top module: `exposure_seq`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `integ_o`, `rd_start_o`, `err_width_o`, `err_short_o` and `err_overrun_o` are all 0.
- R2: Let E be the first clock edge that samples `trig_open_i` high, and let the line stay high for at least MIN_HIGH edges. Then `integ_o` goes high on edge E+MIN_HIGH+START_DLY+1.
- R3: Let F be the first clock edge that samples `trig_close_i` high while a window is open, and let the line stay high for at least MIN_HIGH edges. Then `integ_o` goes low on edge F+MIN_HIGH+STOP_DLY+1, provided the window has then lasted at least MIN_INT cycles.
- R4: A close that would leave `integ_o` high for fewer than MIN_INT cycles leaves it high for exactly MIN_INT cycles instead, and sets `err_short_o`.
- R5: `rd_start_o` is high for exactly one cycle, RD_DLY edges after the edge on which `integ_o` falls.
- R6: A trigger line that is high for fewer than MIN_HIGH consecutive sampling edges has no effect on `integ_o` and sets `err_width_o`.
- R7: An open trigger that qualifies while `integ_o` is high, or while an open latency is still running, is ignored and sets `err_overrun_o`. The open window keeps its timing.
- R8: A close trigger that qualifies while `integ_o` is low is ignored. It produces no readout pulse and changes no flag.
- R9: The readout pulse of one frame and the rising edge of `integ_o` for the next frame may fall on the same cycle, and both take effect.
- R10: `err_width_o`, `err_short_o` and `err_overrun_o` stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_open_i | input | 1 | Asynchronous trigger that opens the exposure window |
| trig_close_i | input | 1 | Asynchronous trigger that closes the exposure window |
| integ_o | output | 1 | High while the exposure window is open |
| rd_start_o | output | 1 | One-cycle pulse that starts readout of the frame just closed |
| err_width_o | output | 1 | Sticky: a trigger pulse was shorter than the minimum high time |
| err_short_o | output | 1 | Sticky: a window was stretched to the minimum length |
| err_overrun_o | output | 1 | Sticky: an open trigger arrived while a window was busy |

## Verification
Two events can land on the same cycle: the readout pulse of the frame that just closed, and the opening of the next frame's window. The bench provokes this by raising the next open trigger before the previous window closes. The raise is timed so that qualification plus open latency ends exactly on the readout cycle. The check passes only if the cycle of the readout pulse and the cycle of the next `integ_o` rise both equal the value the bench predicts, and no overrun flag appears.

// File: rtl/exposure_seq.sv
module exposure_seq #(
  parameter int START_DLY = 10,
  parameter int STOP_DLY  = 130,
  parameter int RD_DLY    = 100,
  parameter int MIN_INT   = 500,
  parameter int MIN_HIGH  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_open_i,
  input  logic trig_close_i,
  output logic integ_o,
  output logic rd_start_o,
  output logic err_width_o,
  output logic err_short_o,
  output logic err_overrun_o
);

  localparam int DMAX = (STOP_DLY > RD_DLY) ? ((STOP_DLY > START_DLY) ? STOP_DLY : START_DLY)
                                            : ((RD_DLY > START_DLY) ? RD_DLY : START_DLY);
  localparam int DW = $clog2(DMAX + 1);
  localparam int HW = $clog2(MIN_HIGH + 1);
  localparam int IW = $clog2(MIN_INT + 1);

  // index 0: open trigger, index 1: close trigger
  logic [1:0]    s1, s2, s2d;
  logic [HW-1:0] hcnt [2];
  logic [1:0]    fire, runt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0; s2 <= '0; s2d <= '0;
      for (int i = 0; i < 2; i++) hcnt[i] <= '0;
    end else begin
      s1  <= {trig_close_i, trig_open_i};
      s2  <= s1;
      s2d <= s2;
      for (int i = 0; i < 2; i++)
        if (!s2[i])                         hcnt[i] <= '0;
        else if (hcnt[i] != HW'(MIN_HIGH))  hcnt[i] <= hcnt[i] + HW'(1);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_qual
    assign fire[g] = s2[g] && (hcnt[g] == HW'(MIN_HIGH - 1));
    assign runt[g] = !s2[g] && s2d[g] && (hcnt[g] < HW'(MIN_HIGH));
  end

  logic          open_pend, close_pend, hold, rd_pend;
  logic [DW-1:0] open_cnt, close_cnt, rd_cnt;
  logic [IW-1:0] icnt;

  wire open_go   = fire[0];
  wire close_go  = fire[1];
  wire open_exp  = open_pend && (open_cnt == DW'(1));
  wire close_exp = close_pend && (close_cnt == DW'(1));
  wire long_ok   = icnt >= IW'(MIN_INT - 1);
  wire closing   = (close_exp || hold) && long_ok;
  wire rd_exp    = rd_pend && (rd_cnt == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_o <= 1'b0; rd_start_o <= 1'b0;
      err_width_o <= 1'b0; err_short_o <= 1'b0; err_overrun_o <= 1'b0;
      open_pend <= 1'b0; close_pend <= 1'b0; hold <= 1'b0; rd_pend <= 1'b0;
      open_cnt <= '0; close_cnt <= '0; rd_cnt <= '0; icnt <= '0;
    end else begin
      if (|runt) err_width_o <= 1'b1;

      if (open_pend) open_cnt <= open_cnt - DW'(1);
      if (open_exp)  open_pend <= 1'b0;
      if (open_go && (integ_o || open_pend)) err_overrun_o <= 1'b1;
      else if (open_go) begin
        open_pend <= 1'b1;
        open_cnt  <= DW'(START_DLY);
      end

      if (!integ_o)                    icnt <= '0;
      else if (icnt != IW'(MIN_INT))   icnt <= icnt + IW'(1);

      if (close_pend) close_cnt <= close_cnt - DW'(1);
      if (close_exp) begin
        close_pend <= 1'b0;
        if (!long_ok) begin
          hold        <= 1'b1;
          err_short_o <= 1'b1;
        end
      end
      if (close_go && integ_o && !close_pend && !hold && !closing) begin
        close_pend <= 1'b1;
        close_cnt  <= DW'(STOP_DLY);
      end

      rd_start_o <= rd_exp;
      if (rd_pend) rd_cnt <= rd_cnt - DW'(1);
      if (rd_exp)  rd_pend <= 1'b0;

      if (open_exp) integ_o <= 1'b1;
      else if (closing) begin
        integ_o    <= 1'b0;
        hold       <= 1'b0;
        close_pend <= 1'b0;
        rd_pend    <= 1'b1;
        rd_cnt     <= DW'(RD_DLY);
      end
    end
  end

  assert_open_R2: assert property (@(posedge clk) disable iff (rst)
    open_exp |=> integ_o);
  assert_min_window_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(integ_o) |-> ($past(icnt) >= IW'(MIN_INT - 1)));
  assert_rd_single_R5: assert property (@(posedge clk) disable iff (rst)
    rd_start_o |=> !rd_start_o);
  assert_runt_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (|runt) |=> err_width_o);
  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (open_go && integ_o) |=> err_overrun_o);
  assert_stop_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (close_go && !integ_o) |=> !close_pend);
  assert_sticky_short_R10: assert property (@(posedge clk) disable iff (rst)
    err_short_o |=> err_short_o);
  assert_sticky_width_R10: assert property (@(posedge clk) disable iff (rst)
    err_width_o |=> err_width_o);
  assert_sticky_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    err_overrun_o |=> err_overrun_o);

endmodule

// File: tb/tb_exposure_seq.sv
module tb_exposure_seq;
  localparam int SD = 10, PD = 130, RD = 100, MI = 500, MH = 100;

  logic clk = 1'b0, rst = 1'b1, t_open = 1'b0, t_close = 1'b0;
  logic integ, rd, e_w, e_s, e_o;
  int total = 0, bad = 0, cyc = 0;
  int on_n = 0, rd_n = 0, t_on = -1, t_off = -1, t_rd = -1;
  logic integ_q = 1'b0;

  exposure_seq #(.START_DLY(SD), .STOP_DLY(PD), .RD_DLY(RD), .MIN_INT(MI), .MIN_HIGH(MH)) dut (
    .clk(clk), .rst(rst), .trig_open_i(t_open), .trig_close_i(t_close),
    .integ_o(integ), .rd_start_o(rd), .err_width_o(e_w), .err_short_o(e_s),
    .err_overrun_o(e_o));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (integ && !integ_q) begin on_n++; t_on = cyc; end
    if (!integ && integ_q) t_off = cyc;
    if (rd) begin rd_n++; t_rd = cyc; end
    integ_q = integ;
  end

  // columns: open high length, close raise offset, close high length, expected short flag after row
  localparam int VEC [4][4] = '{
    '{100,  800, 100, 0},
    '{150, 1000, 300, 0},
    '{120,  300, 100, 1},
    '{200, 2000, 150, 1}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(bit which, int len, output int c);
    @(negedge clk);
    c = cyc;
    if (which) t_close = 1'b1; else t_open = 1'b1;
    repeat (len) @(negedge clk);
    t_open = 1'b0; t_close = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, c2, toff_exp, ton_exp, nom;
    do_reset();
    check("R1 integ", integ, 0); check("R1 rd", rd, 0);
    check("R1 width", e_w, 0); check("R1 short", e_s, 0); check("R1 overrun", e_o, 0);

    for (int r = 0; r < 4; r++) begin
      pulse(1'b0, VEC[r][0], c);
      idle(VEC[r][1] - VEC[r][0] - 1);
      pulse(1'b1, VEC[r][2], c2);
      idle(900);
      ton_exp = c + MH + SD + 2;
      nom = c2 + MH + PD + 2;
      toff_exp = (nom < ton_exp + MI) ? ton_exp + MI : nom;
      check("R2 open time", t_on, ton_exp);
      check("R3/R4 close time", t_off, toff_exp);
      check("R5 readout time", t_rd, t_off + RD);
      check("R4/R10 short flag", e_s, VEC[r][3]);
      check("R6 width flag clear", e_w, 0);
      check("R7 overrun flag clear", e_o, 0);
    end
    check("R5 one pulse per frame", rd_n, 4);

    // R6: runt open pulse
    do_reset();
    on_n = 0;
    pulse(1'b0, MH - 1, c);
    idle(400);
    check("R6 runt no window", on_n, 0);
    check("R6 runt integ", integ, 0);
    check("R6 width flag", e_w, 1);
    check("R10 width sticky", e_w, 1);

    // R8: close with no window open
    do_reset();
    rd_n = 0;
    pulse(1'b1, 150, c);
    idle(600);
    check("R8 no readout", rd_n, 0);
    check("R8 integ low", integ, 0);
    check("R8 flags", {29'd0, e_w, e_s, e_o}, 0);

    // R7: second open during window
    do_reset();
    on_n = 0;
    pulse(1'b0, 100, c);
    idle(199);
    pulse(1'b0, 100, c2);
    idle(599);
    pulse(1'b1, 100, c2);
    idle(700);
    check("R7 overrun flag", e_o, 1);
    check("R7 single window", on_n, 1);
    check("R7 open kept", t_on, c + MH + SD + 2);
    check("R7 close kept", t_off, c2 + MH + PD + 2);

    // R9: readout of frame A coincides with opening of frame B
    do_reset();
    on_n = 0;
    pulse(1'b0, 100, c);
    idle(699);
    pulse(1'b1, 100, c2);
    toff_exp = c2 + MH + PD + 2;
    while (cyc < toff_exp + RD - MH - SD - 3) @(negedge clk);
    pulse(1'b0, 100, c);
    idle(400);
    check("R9 close A", t_off, toff_exp);
    check("R9 readout A", t_rd, toff_exp + RD);
    check("R9 open B same cycle", t_on, t_rd);
    check("R9 open B time", t_on, c + MH + SD + 2);
    check("R9 two windows", on_n, 2);
    check("R9 no overrun", e_o, 0);
    check("R9 B active", integ, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule